// File: doc/BRIEF.md
# Cache Miss Address Sampler

This block takes a periodic sample of cache-miss addresses so that software can build a statistical picture of where misses fall. A free-running miss counter advances by one on every cycle in which the cache reports a miss. Two sample slots share this counter. Slot A latches the miss address on the miss seen while the count is zero. Slot B latches the miss address on the miss seen while the count is 62, which is 62 misses after slot A. Over each 64-miss period this gives two samples.

Each slot has a sticky valid flag. A capture sets the flag. Software clears the flag by writing a one to it. A small register port lets software read the counter, both flags and both addresses. Slot B's valid flag is also returned in bit 0 of slot B's address register, so one read of that register gives both the address and whether it is fresh. Miss detection and the cache are outside this block. It only sees a miss strobe and the miss address.

Top module: `miss_sampler`

## Requirements
- R1: After a synchronous active-low reset, the miss count, both valid flags and both stored addresses are zero.
- R2: The miss count (CNT_W = 6 bits) rises by one on every clock in which `miss_valid` is high, wraps from 63 to 0, and holds on clocks without a miss.
- R3: A miss while the count is 0 stores `miss_addr` into slot A.
- R4: A miss while the count is 62 (2^CNT_W − 2) stores `miss_addr` into slot B. Misses at any other count leave both slots unchanged.
- R5: A capture sets that slot's valid flag and replaces its address, even when the flag is already set.
- R6: A write to offset 0 clears slot A's flag when data bit 8 is 1, and clears slot B's flag when data bit 9 is 1. Zero bits leave the flags alone. Writes to offsets 1 to 3 change nothing.
- R7: When a clearing write and a capture reach the same slot in the same clock, the capture wins and the flag ends up set.
- R8: Reads are combinational from `csr_addr`. Each offset returns the following:
  - offset 0: count in bits [5:0], flag A in bit 8, flag B in bit 9, all other bits zero;
  - offset 1: slot A address;
  - offset 2: slot B address with bit 0 replaced by flag B;
  - offset 3: zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_valid | input | 1 | One miss in this clock |
| miss_addr | input | ADDR_W | Address of the miss |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register offset for read and write |
| csr_wdata | input | DATA_W | Register write data |
| csr_rdata | output | DATA_W | Register read data (combinational) |

## Verification
Every result lands on the first clock edge after its stimulus. A miss updates the counter, and a capture, if due, updates the slot at that edge. A write clears a flag at that edge. The read mux shows the new state in the same cycle. The bench applies inputs just after a falling edge and holds them over one rising edge. It then reads the registers at the following falling edge, so each check sees exactly one edge's worth of change. For the collision case, the bench drives the miss and the clearing write in the same cycle. It then checks the outcome at the next falling edge.

// File: rtl/mss_pkg.sv
// Package: shared register offsets and status bit positions of the miss sampler.
// Assumes the count field fits below the flag bits (CNT_W <= 8).
package mss_pkg;
    typedef enum logic [1:0] {
        CSR_STATUS   = 2'd0,
        CSR_SAMPLE_A = 2'd1,
        CSR_SAMPLE_B = 2'd2,
        CSR_SPARE    = 2'd3
    } csr_off_e;

    localparam int FLAG_A_BIT = 8;
    localparam int FLAG_B_BIT = 9;
    localparam int NUM_SLOTS  = 2;
endpackage

// File: rtl/mss_miss_counter.sv
// Module: free-running miss counter. It advances once per miss and wraps
// naturally at 2**CNT_W. Assumes at most one miss per clock.
module mss_miss_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    output logic [CNT_W-1:0] count
);
    // Count misses; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (miss_valid) count <= count + 1'b1;
    end

    // R2: a miss moves the count forward by exactly one.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> count == CNT_W'($past(count) + 1'b1));

    // R2: no miss, no movement.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> $stable(count));
endmodule

// File: rtl/mss_slot.sv
// Module: one sample slot. It stores the miss address when a miss arrives
// at its trigger count, and keeps a sticky valid flag that a clear request
// drops unless a capture happens in the same clock.
module mss_slot #(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 6,
    parameter int TRIGGER = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              clr_req,
    output logic [ADDR_W-1:0] addr_q,
    output logic              valid_q
);
    localparam logic [CNT_W-1:0] TRIG = CNT_W'(TRIGGER);

    logic hit;

    // Decide whether this miss is the one this slot samples.
    always_comb hit = miss_valid && (count == TRIG);

    // Store the address on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr_q <= '0;
        else if (hit) addr_q <= miss_addr;
    end

    // Sticky flag: a capture sets it and takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        valid_q <= 1'b0;
        else if (hit)      valid_q <= 1'b1;
        else if (clr_req)  valid_q <= 1'b0;
    end

    // R5: a capture leaves the flag set and the sampled address stored.
    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && count == TRIG) |=> (valid_q && addr_q == $past(miss_addr)));

    // R6: a clear without a capture drops the flag.
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(miss_valid && count == TRIG)) |=> !valid_q);

    // R7: a capture beats a clear in the same clock.
    assert_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && miss_valid && count == TRIG) |=> valid_q);

    // R4: outside the trigger count, the slot holds its state.
    assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !(miss_valid && count == TRIG)) |=> ($stable(valid_q) && $stable(addr_q)));
endmodule

// File: rtl/mss_csr_read.sv
// Module: combinational read mux over the sampler state. Assumes
// ADDR_W <= DATA_W and CNT_W <= 8. Slot B's flag replaces bit 0 of its
// address on read.
module mss_csr_read
    import mss_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic [1:0]        csr_addr,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              valid_a,
    input  logic              valid_b,
    output logic [DATA_W-1:0] csr_rdata
);
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] word_b;

    // Assemble the status word and the slot B word.
    always_comb begin
        status_word             = '0;
        status_word[CNT_W-1:0]  = count;
        status_word[FLAG_A_BIT] = valid_a;
        status_word[FLAG_B_BIT] = valid_b;
        word_b                  = DATA_W'(addr_b);
        word_b[0]               = valid_b;
    end

    // Select the word for the given offset.
    always_comb begin
        unique case (csr_off_e'(csr_addr))
            CSR_STATUS:   csr_rdata = status_word;
            CSR_SAMPLE_A: csr_rdata = DATA_W'(addr_a);
            CSR_SAMPLE_B: csr_rdata = word_b;
            default:      csr_rdata = '0;
        endcase
    end

    // R8: the offset 2 word always carries flag B in bit 0.
    always_comb begin
        if (csr_addr == 2'd2) assert_mirror_R8: assert (csr_rdata[0] == valid_b);
    end
endmodule

// File: rtl/miss_sampler.sv
// Module: cache miss address sampler top. One shared miss counter drives
// two sample slots 2**CNT_W-2 counts apart. Register writes to the status
// offset clear flags; other offsets are read-only.
module miss_sampler
    import mss_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              csr_wr,
    input  logic [1:0]        csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata
);
    localparam int SLOT_B_TRIG = (1 << CNT_W) - 2;
    localparam int FLAG_BITS [NUM_SLOTS] = '{FLAG_A_BIT, FLAG_B_BIT};

    logic [CNT_W-1:0]  count;
    logic              stat_wr;
    logic [ADDR_W-1:0] slot_addr  [NUM_SLOTS];
    logic              slot_valid [NUM_SLOTS];
    logic              slot_clr   [NUM_SLOTS];

    mss_miss_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .count      (count)
    );

    // Decode a write to the status offset.
    always_comb stat_wr = csr_wr && (csr_addr == CSR_STATUS);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Raise this slot's clear request from its one-bit write mask.
        always_comb slot_clr[s] = stat_wr && csr_wdata[FLAG_BITS[s]];

        mss_slot #(
            .ADDR_W  (ADDR_W),
            .CNT_W   (CNT_W),
            .TRIGGER ((s == 0) ? 0 : SLOT_B_TRIG)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .miss_valid (miss_valid),
            .miss_addr  (miss_addr),
            .count      (count),
            .clr_req    (slot_clr[s]),
            .addr_q     (slot_addr[s]),
            .valid_q    (slot_valid[s])
        );
    end

    mss_csr_read #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
        .csr_addr  (csr_addr),
        .count     (count),
        .addr_a    (slot_addr[0]),
        .addr_b    (slot_addr[1]),
        .valid_a   (slot_valid[0]),
        .valid_b   (slot_valid[1]),
        .csr_rdata (csr_rdata)
    );

    // R3: slot A never changes while the count is away from zero.
    assert_a_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |=> $stable(slot_addr[0]));

    // R1: state is clear in the cycle after reset.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !slot_valid[0] && !slot_valid[1]));
endmodule

// File: tb/miss_sampler_tb.sv
`timescale 1ns/1ps
module miss_sampler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        csr_wr = 1'b0;
    logic [1:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    miss_sampler u_dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] off, output logic [31:0] val);
        csr_addr = off;
        #0.5;
        val = csr_rdata;
    endtask

    // One clock with optional miss and optional write, then back to idle.
    task automatic step(input bit m, input logic [31:0] a, input bit w,
                        input logic [1:0] off, input logic [31:0] d);
        @(negedge clk);
        miss_valid = m; miss_addr = a; csr_wr = w; csr_addr = off; csr_wdata = d;
        @(negedge clk);
        miss_valid = 1'b0; csr_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); chk("R1 status", v, 32'h0);
        rd(2'd1, v); chk("R1 slotA", v, 32'h0);
        rd(2'd2, v); chk("R1 slotB", v, 32'h0);
        rd(2'd3, v); chk("R8 spare", v, 32'h0);
    endtask

    task automatic t_idle;
        logic [31:0] v;
        repeat (3) step(0, 32'hFFFF_FFF0, 0, 0, 0);
        rd(2'd0, v); chk("R2 idle hold", v, 32'h0);
    endtask

    task automatic t_slot_a;
        logic [31:0] v;
        step(1, 32'hA000_0010, 0, 0, 0);
        rd(2'd0, v); chk("R3 status after A", v, 32'h0000_0101);
        rd(2'd1, v); chk("R3 slotA addr", v, 32'hA000_0010);
        rd(2'd2, v); chk("R4 slotB untouched", v, 32'h0);
    endtask

    task automatic t_slot_b;
        logic [31:0] v;
        for (int i = 1; i <= 61; i++) step(1, 32'h100 + i * 16, 0, 0, 0);
        rd(2'd0, v); chk("R2 count 62", v, 32'h0000_013E);
        rd(2'd1, v); chk("R4 A held", v, 32'hA000_0010);
        step(1, 32'hB000_0040, 0, 0, 0);
        rd(2'd2, v); chk("R8 slotB with flag", v, 32'hB000_0041);
        rd(2'd0, v); chk("R4 status after B", v, 32'h0000_033F);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        step(1, 32'hEEEE_0000, 0, 0, 0);
        rd(2'd0, v); chk("R2 wrap", v, 32'h0000_0300);
        rd(2'd1, v); chk("R4 no capture at 63", v, 32'hA000_0010);
    endtask

    task automatic t_write_ignored;
        logic [31:0] v;
        step(0, 0, 1, 2'd0, 32'h0000_0000);
        rd(2'd0, v); chk("R6 write zero", v, 32'h0000_0300);
        step(0, 0, 1, 2'd1, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R6 other offset flags", v, 32'h0000_0300);
        rd(2'd1, v); chk("R6 other offset addr", v, 32'hA000_0010);
    endtask

    task automatic t_clear_b;
        logic [31:0] v;
        step(0, 0, 1, 2'd0, 32'h0000_0200);
        rd(2'd0, v); chk("R6 clear B", v, 32'h0000_0100);
        rd(2'd2, v); chk("R8 mirror cleared", v, 32'hB000_0040);
    endtask

    task automatic t_overwrite;
        logic [31:0] v;
        step(1, 32'hC000_0080, 0, 0, 0);
        rd(2'd1, v); chk("R5 overwrite A", v, 32'hC000_0080);
        rd(2'd0, v); chk("R5 flag stays set", v, 32'h0000_0101);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        for (int i = 1; i <= 63; i++) step(1, 32'h200 + i * 16, 0, 0, 0);
        rd(2'd2, v); chk("R4 second period B", v, 32'h0000_05E1);
        step(1, 32'hD000_0080, 1, 2'd0, 32'h0000_0300);
        rd(2'd0, v); chk("R7 capture beats clear", v, 32'h0000_0101);
        rd(2'd1, v); chk("R7 A addr", v, 32'hD000_0080);
        step(0, 0, 1, 2'd0, 32'h0000_0100);
        rd(2'd0, v); chk("R6 clear A", v, 32'h0000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_slot_a();
        t_slot_b();
        t_wrap();
        t_write_ignored();
        t_clear_b();
        t_overwrite();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule